// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block is the column counter that sits behind the command decoder of a synchronous DRAM device. When a read or write column command is decoded, the block is handed the 8-bit starting column and a strobe. From the next clock on it presents one column address per cycle until the burst ends. It then drops its valid flag.

Two mode fields select the number of beats and the wrap order. The wrap order is either sequential (an increment inside an aligned block) or interleaved (XOR of the beat index into the low bits). A full-page setting keeps incrementing around all 256 columns of the open row until it is stopped. A new column command may arrive on any cycle, including the cycle right after the previous one. It restarts the count at once.

A single-write mode bit reduces write bursts to one location while reads keep the programmed length. The mode fields and the write qualifiers are captured with the start strobe, so the burst in flight is not affected when they change later. A last-beat flag marks the final address of every fixed-length burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset is released, and before any start strobe, `valid_o` and `last_o` are 0.
- R2: In the cycle after a clock edge at which `start_i` is 1, `valid_o` is 1 and `col_o` equals the `start_col_i` sampled at that edge. That is beat 0.
- R3: The length code `len_code_i` maps 0 to 1 beat, 1 to 2 beats, 2 to 4 beats, 3 to 8 beats and 7 to full page. The reserved codes 4, 5 and 6 give a single beat.
- R4: With `ilv_i`=0 and a length of 2^k beats (k = 1..3), beat n is (start with its low k bits cleared) plus ((start + n) mod 2^k). The upper bits never change during the burst.
- R5: With `ilv_i`=1 and a length of 2^k beats, beat n is start XOR n, where n < 2^k.
- R6: In full-page mode, beat n is (start + n) mod 256. The beats continue without end until a stop or a new start, and `ilv_i` has no effect.
- R7: `last_o` is 1 exactly on the final beat of a fixed-length burst. `valid_o` is 0 in the following cycle unless a new start was sampled.
- R8: `last_o` is never 1 during a full-page burst.
- R9: A `stop_i` sampled with `start_i`=0 makes `valid_o` 0 in the next cycle. When `start_i` and `stop_i` are both 1, the start takes effect.
- R10: A start sampled during a burst in flight abandons that burst. The next cycle shows beat 0 of the new burst.
- R11: When `write_i`=1 and `single_write_i`=1 at the start, the burst has one beat whatever the length code. Reads, and writes with `single_write_i`=0, use the programmed length.
- R12: `len_code_i`, `ilv_i`, `write_i`, `single_write_i` and `start_col_i` are ignored while `start_i` is 0. Changing them during a burst does not alter its addresses or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command strobe (read or write) |
| start_col_i | input | 8 | Starting column address |
| write_i | input | 1 | 1 when the command is a write |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| single_write_i | input | 1 | Restricts write bursts to one beat |
| stop_i | input | 1 | Burst stop |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | `col_o` holds a beat of a live burst |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
A corrupted beat counter or a wrong latched mask would show on `col_o` at the next beat. Either fault breaks the ordering that R4 and R5 give for some start offset. A wrong latched length would move `last_o` off its beat, or leave `valid_o` high one cycle too long or drop it one cycle too early, and that shows by the end of the burst. Every fixed length, both orders and all 256 offsets are swept while the mode inputs are scrambled in flight, so a stale or re-sampled mode field surfaces within eight cycles of the start.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'd0,
    BL_TWO  = 3'd1,
    BL_FOUR = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;

  localparam int unsigned MAX_LG = 3;  // largest fixed burst is 2**MAX_LG beats
endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             write_i,
  input  logic             single_write_i,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] last_idx_o,
  output logic             page_o,
  output logic             ilv_o
);
  localparam int unsigned LG_W = $clog2(MAX_LG + 1);

  logic [LG_W-1:0] lg;
  logic            one_beat;

  assign one_beat = write_i & single_write_i;

  always_comb begin
    page_o = 1'b0;
    lg     = '0;
    case (bl_code_e'(len_code_i))
      BL_TWO:   lg = LG_W'(1);
      BL_FOUR:  lg = LG_W'(2);
      BL_EIGHT: lg = LG_W'(3);
      BL_PAGE:  page_o = 1'b1;
      default:  lg = '0;  // one beat, also for reserved codes
    endcase
    if (one_beat) begin
      page_o = 1'b0;
      lg     = '0;
    end
  end

  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    assign mask_o[g] = page_o | (32'(lg) > g);
  end

  // beats-1 equals the wrap mask for power-of-two lengths
  assign last_idx_o = mask_o;
  assign ilv_o      = ilv_i & ~page_o;

  always_comb begin
    if (one_beat) begin
      AST_SINGLE_WRITE_ONE: assert (last_idx_o == '0 && !page_o); // R11
    end
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] last_idx_i,
  input  logic             page_i,
  output logic [COL_W-1:0] cnt_o,
  output logic             active_o,
  output logic             last_o,
  output logic             page_o
);
  logic [COL_W-1:0] cnt_q, last_idx_q;
  logic             page_q, act_q, at_end;

  assign at_end = act_q & ~page_q & (cnt_q == last_idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      last_idx_q <= '0;
      page_q     <= 1'b0;
      act_q      <= 1'b0;
    end else if (load_i) begin
      cnt_q      <= '0;
      last_idx_q <= last_idx_i;
      page_q     <= page_i;
      act_q      <= 1'b1;
    end else if (stop_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (at_end) act_q <= 1'b0;
      else        cnt_q <= cnt_q + 1'b1;  // wraps modulo 2**COL_W in page mode
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = act_q;
  assign last_o   = at_end;
  assign page_o   = page_q;

  AST_LOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> act_q && cnt_q == '0); // R2
  AST_END_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_end && !load_i && !stop_i |=> !act_q); // R7
  AST_STOP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !load_i |=> !act_q); // R9
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && !at_end && !load_i && !stop_i |=> act_q && cnt_q == $past(cnt_q) + 1'b1); // R6
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = base_i + cnt_i;

  always_comb begin
    if (ilv_i) col_o = base_i ^ (cnt_i & mask_i);
    else       col_o = (base_i & ~mask_i) | (sum & mask_i);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             write_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             single_write_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] d_mask, d_last_idx, cnt;
  logic             d_page, d_ilv, page;
  logic [COL_W-1:0] base_q, mask_q;
  logic             ilv_q;

  bcg_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code_i    (len_code_i),
    .ilv_i         (ilv_i),
    .write_i       (write_i),
    .single_write_i(single_write_i),
    .mask_o        (d_mask),
    .last_idx_o    (d_last_idx),
    .page_o        (d_page),
    .ilv_o         (d_ilv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= start_col_i;
      mask_q <= d_mask;
      ilv_q  <= d_ilv;
    end
  end

  bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_i),
    .stop_i    (stop_i),
    .last_idx_i(d_last_idx),
    .page_i    (d_page),
    .cnt_o     (cnt),
    .active_o  (valid_o),
    .last_o    (last_o),
    .page_o    (page)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base_i(base_q),
    .cnt_i (cnt),
    .mask_i(mask_q),
    .ilv_i (ilv_q),
    .col_o (col_o)
  );

  AST_RESTART_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(start_col_i)); // R10
  AST_UPPER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !page && !start_i && !stop_i && !last_o |=>
      (col_o & ~mask_q) == ($past(col_o) & ~mask_q)); // R4
  AST_PAGE_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && page |-> !last_o); // R8
  AST_LAST_IS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R7
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic       write_i = 1'b0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       single_write_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  burst_col_gen u_burst_col_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .write_i(write_i), .len_code_i(len_code_i), .ilv_i(ilv_i),
    .single_write_i(single_write_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_col(input int base, input int n, input int lg,
                                   input int ilv, input int page);
    int blk;
    if (page != 0) return (base + n) % 256;
    blk = 1 << lg;
    if (ilv != 0) return base ^ n;
    return (base / blk) * blk + ((base % blk) + n) % blk;
  endfunction

  // issue a start at the current negedge; leaves the bench at the negedge with beat 0 visible
  task automatic issue(input int code, input int ilv, input int base, input int wr, input int sw);
    start_i = 1'b1; len_code_i = 3'(code); ilv_i = ilv[0];
    start_col_i = 8'(base); write_i = wr[0]; single_write_i = sw[0];
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // full fixed burst with scrambled mode inputs after the start (R12)
  task automatic run_burst(input int code, input int ilv, input int base, input int wr,
                           input int sw, input int beats, input int lg, input string req);
    issue(code, ilv, base, wr, sw);
    len_code_i = 3'd7; ilv_i = ~ilv_i; start_col_i = ~start_col_i;
    write_i = ~write_i; single_write_i = ~single_write_i;
    for (int n = 0; n < beats; n++) begin
      chk(valid_o && col_o == 8'(model_col(base, n, lg, ilv, 0)), req, col_o,
          model_col(base, n, lg, ilv, 0));
      chk(last_o == (n == beats - 1), "R7", last_o, (n == beats - 1));
      @(negedge clk_i);
    end
    chk(!valid_o && !last_o, "R7", valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && !last_o, "R1", {valid_o, last_o}, 0);

    // R3 R4 R5 R12: every fixed length, both orders, every start offset
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int base = 0; base < 256; base++)
          run_burst(code, ilv, base, 0, 0, 1 << code, code, (ilv != 0) ? "R5" : "R4");

    // R3: reserved codes give one beat
    for (int code = 4; code < 7; code++)
      run_burst(code, 0, 37 + code, 0, 0, 1, 0, "R3");

    // R11: single write collapses writes only
    run_burst(3, 0, 8'h5c, 1, 1, 1, 0, "R11");
    run_burst(3, 1, 8'h5c, 1, 0, 8, 3, "R11");
    run_burst(3, 0, 8'h5c, 0, 1, 8, 3, "R11");

    // R12: mode change in flight, length 2 sequential from 6
    run_burst(1, 0, 6, 0, 0, 2, 1, "R12");

    // R6 R8: full page wraps past 255, interleave ignored, stop ends it
    issue(7, 1, 250, 0, 0);
    for (int n = 0; n < 300; n++) begin
      chk(valid_o && col_o == 8'(model_col(250, n, 0, 0, 1)), "R6", col_o,
          model_col(250, n, 0, 0, 1));
      chk(!last_o, "R8", last_o, 0);
      @(negedge clk_i);
    end
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    chk(!valid_o, "R9", valid_o, 0);

    // R9: stop in a fixed burst after two beats
    issue(3, 0, 5, 0, 0);
    @(negedge clk_i);
    chk(valid_o && col_o == 8'd6, "R9", col_o, 6);
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    chk(!valid_o, "R9", valid_o, 0);

    // R9: start and stop together, start wins
    stop_i = 1'b1;
    issue(2, 0, 8'h21, 0, 0);
    stop_i = 1'b0;
    chk(valid_o && col_o == 8'h21, "R9", col_o, 8'h21);
    @(negedge clk_i);
    chk(valid_o && col_o == 8'h22, "R9", col_o, 8'h22);

    // R10: interrupt after three beats with a 4-beat interleaved burst from 0x43
    issue(3, 0, 8'h10, 0, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    chk(col_o == 8'h12, "R10", col_o, 8'h12);
    issue(2, 1, 8'h43, 0, 0);
    for (int n = 0; n < 4; n++) begin
      chk(valid_o && col_o == 8'(8'h43 ^ n), "R10", col_o, 8'h43 ^ n);
      chk(last_o == (n == 3), "R7", last_o, (n == 3));
      @(negedge clk_i);
    end
    chk(!valid_o, "R7", valid_o, 0);

    // R10: back-to-back single-beat commands, one per cycle
    for (int k = 0; k < 4; k++) begin
      issue(0, 0, 100 + k, 0, 0);
      chk(valid_o && last_o && col_o == 8'(100 + k), "R10", col_o, 100 + k);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule